// File: doc/BRIEF.md
# SPI Mode-0 Serial Memory Front End

This block is the serial side of a small byte-addressed nonvolatile memory. It watches a mode-0 SPI link (clock idles low, data taken on the rising clock edge, data launched on the falling edge) by oversampling the pins with the system clock. After chip select goes low it reads a one-byte command. It then collects a 16-bit address, streams bytes out of an internal synchronous RAM, and returns a status byte. Write-type commands are handed on as a stream of received data bytes and a final commit pulse. The pulse goes to a separate protection and program controller, which owns the array contents, the protection bits and the busy flag.

The control is one state machine with these states: `ST_IDLE` (deselected), `ST_OPCODE` (collecting the command byte), `ST_ADDR` (collecting two address bytes), `ST_RDATA` (streaming array bytes), `ST_WDATA` (collecting bytes to program), `ST_STAT` (streaming the status byte) and `ST_DROP` (ignoring the rest of the transaction). Chip select high forces `ST_IDLE` from any state. From `ST_IDLE`, chip select low moves to `ST_OPCODE`. At the end of the command byte the machine moves to `ST_ADDR` for a read, or for a write while write-enabled. It moves to `ST_WDATA` for a status write while write-enabled, and to `ST_STAT` for a status read. Every other case goes to `ST_DROP`. At the end of the second address byte it moves to `ST_RDATA` for a read and `ST_WDATA` for a write.

Top module: `spi_mem_slave`

## Requirements
- R1: SDI is taken on rising SCK and SDO changes on falling SCK, MSB first. The command codes are 0x06 set write-enable, 0x04 clear write-enable, 0x05 status read, 0x01 status write, 0x03 array read and 0x02 array write.
- R2: After reset, and within two clocks of chip select going high, `spi_sdo_oe` is low and the machine is idle.
- R3: After 0x03 and a 16-bit address (MSB first), successive bytes come from successive addresses, starting at the given one.
- R4: Only the low ADDR_W bits of the address select a byte. The upper bits have no effect on read data or on the commit address.
- R5: A read stream continues from the top address to address 0 without limit.
- R6: The status byte is {wpen, 0, 0, 0, bp[1], bp[0], write-enable, busy}. It repeats for as long as clocks continue.
- R7: Write-enable is set at the end of a 0x06 byte and cleared at the end of a 0x04 byte. It is also cleared when `prog_busy` falls.
- R8: While `prog_busy` is high the status byte reads 0xFF. Reads and writes started in that time produce no SDO drive, no data strobe and no commit.
- R9: An array write or status write received while write-enable is clear produces no data strobe and no commit.
- R10: Each complete data byte of an accepted write gives a one-cycle `dat_vld` with the byte on `dat_byte`. For an array write these bytes follow the address; for a status write they follow the command byte.
- R11: A single-cycle `cmt_req` is issued only when chip select rises with SCK low, on a byte boundary, after at least one data byte. `cmt_status` marks a status write, and `cmt_addr` carries the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Output enable for SDO |
| stat_wpen | input | 1 | Pin-protect enable bit from the controller |
| stat_bp | input | 2 | Block-protect level from the controller |
| prog_busy | input | 1 | Program cycle in progress |
| arr_we | input | 1 | Array write strobe from the controller |
| arr_waddr | input | ADDR_W | Array write address |
| arr_wdata | input | 8 | Array write data |
| dat_vld | output | 1 | Received data byte strobe |
| dat_byte | output | 8 | Received data byte |
| cmt_req | output | 1 | Commit pulse |
| cmt_status | output | 1 | Commit targets the status bits |
| cmt_addr | output | ADDR_W | Start address of the commit |

## Verification
The bench builds the block with ADDR_W set to 8, so the array has 256 bytes. With that size, the wrap from 0xFF to 0x00 and the don't-care upper address byte can both be reached in a few transfers. SCK runs at one eighth of the system clock. This leaves several clocks between each SCK edge and the next, which exposes the one-cycle RAM read latency and the pin registering. The bench plays the controller: it preloads the array through the write port and drives `prog_busy`.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_STAT,
        ST_DROP
    } fe_state_t;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic sdi,
    output logic sck_q,
    output logic cs_q,
    output logic sdi_q,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_d;
    logic cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sck_d <= 1'b0;
            cs_q  <= 1'b1;
            cs_d  <= 1'b1;
            sdi_q <= 1'b0;
        end else begin
            sck_q <= sck;
            sck_d <= sck_q;
            cs_q  <= cs_n;
            cs_d  <= cs_q;
            sdi_q <= sdi;
        end
    end

    assign sck_rise = sck_q & ~sck_d;
    assign sck_fall = ~sck_q & sck_d;
    assign cs_rise  = cs_q & ~cs_d;
endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    input  logic              stat_wpen,
    input  logic [1:0]        stat_bp,
    input  logic              prog_busy,
    input  logic              arr_we,
    input  logic [ADDR_W-1:0] arr_waddr,
    input  logic [7:0]        arr_wdata,
    output logic              dat_vld,
    output logic [7:0]        dat_byte,
    output logic              cmt_req,
    output logic              cmt_status,
    output logic [ADDR_W-1:0] cmt_addr
);
    localparam int FIELD_W = 16;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W);

    logic sck_q, cs_q, sdi_q, sck_rise, sck_fall, cs_rise;

    spi_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .sdi      (spi_sdi),
        .sck_q    (sck_q),
        .cs_q     (cs_q),
        .sdi_q    (sdi_q),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    fe_state_t           st, st_nx, op_nx;
    logic [BYTE_W-1:0]   rx_sr, tx_sr, ram_q, stat_byte, tx_src, rx_byte;
    logic [CNT_W-1:0]    rx_cnt, tx_cnt;
    logic [FIELD_W-1:0]  addr_sr, addr_nx;
    logic [ADDR_W-1:0]   rd_addr;
    logic                addr_hi, rd_is_read, wr_status, got_byte;
    logic                wen_q, busy_d, byte_done;

    spi_mem_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (ram_q)
    );

    assign rx_byte   = {rx_sr[BYTE_W-2:0], sdi_q};
    assign addr_nx   = {addr_sr[FIELD_W-2:0], sdi_q};
    assign byte_done = sck_rise && (rx_cnt == CNT_W'(BYTE_W - 1));
    assign stat_byte = prog_busy ? {BYTE_W{1'b1}}
                                 : {stat_wpen, 3'b000, stat_bp, wen_q, 1'b0};
    assign tx_src    = (st == ST_STAT) ? stat_byte : ram_q;

    // command decode at the end of the first byte
    always_comb begin
        op_nx = ST_DROP;
        if (prog_busy) begin
            if (rx_byte == OP_RDSR) op_nx = ST_STAT;
        end else begin
            unique case (rx_byte)
                OP_RDSR:  op_nx = ST_STAT;
                OP_READ:  op_nx = ST_ADDR;
                OP_WRITE: op_nx = wen_q ? ST_ADDR : ST_DROP;
                OP_WRSR:  op_nx = wen_q ? ST_WDATA : ST_DROP;
                default:  op_nx = ST_DROP;
            endcase
        end
    end

    always_comb begin
        st_nx = st;
        if (cs_q) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   st_nx = ST_OPCODE;
                ST_OPCODE: if (byte_done) st_nx = op_nx;
                ST_ADDR:   if (byte_done && addr_hi)
                               st_nx = rd_is_read ? ST_RDATA : ST_WDATA;
                default:   st_nx = st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr      <= '0;
            rx_cnt     <= '0;
            tx_sr      <= '0;
            tx_cnt     <= '0;
            addr_sr    <= '0;
            addr_hi    <= 1'b0;
            rd_addr    <= '0;
            rd_is_read <= 1'b0;
            wr_status  <= 1'b0;
            got_byte   <= 1'b0;
            wen_q      <= 1'b0;
            busy_d     <= 1'b0;
            spi_sdo    <= 1'b0;
            spi_sdo_oe <= 1'b0;
            dat_vld    <= 1'b0;
            dat_byte   <= '0;
            cmt_req    <= 1'b0;
            cmt_status <= 1'b0;
            cmt_addr   <= '0;
        end else begin
            dat_vld <= 1'b0;
            cmt_req <= 1'b0;
            busy_d  <= prog_busy;
            if (busy_d && !prog_busy) wen_q <= 1'b0;

            if (cs_rise && st == ST_WDATA && rx_cnt == '0 && got_byte && !sck_q) begin
                cmt_req    <= 1'b1;
                cmt_status <= wr_status;
                cmt_addr   <= wr_status ? '0 : addr_sr[ADDR_W-1:0];
            end

            if (cs_q) begin
                rx_cnt     <= '0;
                tx_cnt     <= '0;
                addr_hi    <= 1'b0;
                got_byte   <= 1'b0;
                spi_sdo_oe <= 1'b0;
            end else begin
                if (sck_rise) begin
                    rx_sr  <= rx_byte;
                    rx_cnt <= rx_cnt + 1'b1;
                    if (st == ST_OPCODE && byte_done && !prog_busy) begin
                        if (rx_byte == OP_WREN) wen_q <= 1'b1;
                        if (rx_byte == OP_WRDI) wen_q <= 1'b0;
                        rd_is_read <= (rx_byte == OP_READ);
                        wr_status  <= (rx_byte == OP_WRSR);
                    end
                    if (st == ST_ADDR) begin
                        addr_sr <= addr_nx;
                        if (byte_done) begin
                            addr_hi <= 1'b1;
                            if (addr_hi) rd_addr <= addr_nx[ADDR_W-1:0];
                        end
                    end
                    if (st == ST_WDATA && byte_done) begin
                        dat_vld  <= 1'b1;
                        dat_byte <= rx_byte;
                        got_byte <= 1'b1;
                    end
                end
                if (sck_fall && (st == ST_RDATA || st == ST_STAT)) begin
                    spi_sdo_oe <= 1'b1;
                    tx_cnt     <= tx_cnt + 1'b1;
                    if (tx_cnt == '0) begin
                        spi_sdo <= tx_src[BYTE_W-1];
                        tx_sr   <= {tx_src[BYTE_W-2:0], 1'b0};
                        if (st == ST_RDATA) rd_addr <= rd_addr + 1'b1;
                    end else begin
                        spi_sdo <= tx_sr[BYTE_W-1];
                        tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R2: deselect releases SDO and returns to idle
    a_r2_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> !spi_sdo_oe);
    a_r2_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> (st == ST_IDLE));
    // R11: commit is a single pulse
    a_r11_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_req |=> !cmt_req);
    // R9: commit and data strobes need write-enable
    a_r9_commit_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_req |-> wen_q);
    // R10: data strobes come only out of the data-collect state
    a_r10_data_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        dat_vld |-> ($past(st) == ST_WDATA));
    // R8: status leads with a one while busy
    a_r8_busy_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && !cs_q && st == ST_STAT && tx_cnt == '0 && prog_busy) |=> spi_sdo);
endmodule

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;
    localparam int AW = 8;
    localparam int HALF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_sck = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_sdi = 1'b0;
    logic          spi_sdo, spi_sdo_oe;
    logic          stat_wpen = 1'b0;
    logic [1:0]    stat_bp = 2'b00;
    logic          prog_busy = 1'b0;
    logic          arr_we = 1'b0;
    logic [AW-1:0] arr_waddr = '0;
    logic [7:0]    arr_wdata = '0;
    logic          dat_vld, cmt_req, cmt_status;
    logic [7:0]    dat_byte;
    logic [AW-1:0] cmt_addr;

    int n_chk = 0;
    int n_err = 0;
    int n_dat = 0;
    int n_cmt = 0;
    int cs_hi = 0;
    logic [7:0]    last_dat = '0;
    logic          last_cst = 1'b0;
    logic [AW-1:0] last_cad = '0;
    logic [7:0]    mem_m [256];
    logic          wen_m = 1'b0;

    always #5 clk = ~clk;

    spi_mem_slave #(.ADDR_W(AW)) u_spi_mem_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .stat_wpen(stat_wpen), .stat_bp(stat_bp), .prog_busy(prog_busy),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .dat_vld(dat_vld), .dat_byte(dat_byte), .cmt_req(cmt_req),
        .cmt_status(cmt_status), .cmt_addr(cmt_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock reference: strobe counting and SDO release while deselected
    always @(negedge clk) begin
        if (rst_n) begin
            if (dat_vld) begin n_dat++; last_dat = dat_byte; end
            if (cmt_req) begin n_cmt++; last_cst = cmt_status; last_cad = cmt_addr; end
            cs_hi = spi_cs_n ? cs_hi + 1 : 0;
            if (cs_hi >= 3) chk("R2 oe while deselected", 32'(spi_sdo_oe), 32'd0);
        end
    end

    task automatic sel();
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_sdi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_sdo;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel(); xb(op, r); desel();
        if (!prog_busy && op == 8'h06) wen_m = 1'b1;
        if (!prog_busy && op == 8'h04) wen_m = 1'b0;
    endtask

    task automatic rdsr(input string tag, input logic [7:0] exp);
        logic [7:0] r;
        sel(); xb(8'h05, r);
        xb(8'h00, r); chk({tag, " status byte"}, 32'(r), 32'(exp));
        xb(8'h00, r); chk({tag, " status repeat R6"}, 32'(r), 32'(exp));
        desel();
    endtask

    task automatic rd_seq(input string tag, input logic [15:0] a, input int n);
        logic [7:0] r;
        sel(); xb(8'h03, r); xb(a[15:8], r); xb(a[7:0], r);
        for (int k = 0; k < n; k++) begin
            xb(8'h5A, r);
            chk(tag, 32'(r), 32'(mem_m[(int'(a) + k) % 256]));
        end
        chk({tag, " R1 oe during read"}, 32'(spi_sdo_oe), 32'd1);
        desel();
    endtask

    logic [7:0] rb;
    int d0, c0;
    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 reset oe", 32'(spi_sdo_oe), 32'd0);
        chk("R2 reset commit", 32'(cmt_req), 32'd0);
        for (int i = 0; i < 256; i++) begin
            mem_m[i] = 8'((i * 37 + 11) & 8'hFF);
            arr_we = 1'b1; arr_waddr = AW'(i); arr_wdata = mem_m[i];
            @(negedge clk);
        end
        arr_we = 1'b0;

        // R6 status layout, R7 write-enable set and clear
        rdsr("R6 idle", 8'h00);
        stat_wpen = 1'b1; stat_bp = 2'b10;
        rdsr("R6 wpen bp", 8'h88);
        cmd1(8'h06);
        rdsr("R7 after set", 8'h8A);
        cmd1(8'h04);
        rdsr("R7 after clear", 8'h88);
        stat_wpen = 1'b0; stat_bp = 2'b01;

        // R3 read stream, R4 upper bits ignored, R5 wrap
        rd_seq("R3 read stream", 16'h0010, 4);
        rd_seq("R4 upper address bits", 16'hAB10, 2);
        rd_seq("R5 wrap to zero", 16'h00FD, 6);

        // R9 write without enable
        d0 = n_dat; c0 = n_cmt;
        sel(); xb(8'h02, rb); xb(8'h12, rb); xb(8'h40, rb); xb(8'hC3, rb); desel();
        chk("R9 no data strobe", 32'(n_dat - d0), 32'd0);
        chk("R9 no commit", 32'(n_cmt - c0), 32'd0);

        // R10 R11 accepted array write
        cmd1(8'h06);
        d0 = n_dat; c0 = n_cmt;
        sel(); xb(8'h02, rb); xb(8'h12, rb); xb(8'h40, rb);
        xb(8'hA1, rb); xb(8'hB2, rb); xb(8'hC3, rb); desel();
        chk("R10 data strobes", 32'(n_dat - d0), 32'd3);
        chk("R10 last byte", 32'(last_dat), 32'hC3);
        chk("R11 commit once", 32'(n_cmt - c0), 32'd1);
        chk("R11 commit addr", 32'(last_cad), 32'h40);
        chk("R11 commit kind", 32'(last_cst), 32'd0);

        // R11 chip select rising mid-byte: no commit
        d0 = n_dat; c0 = n_cmt;
        sel(); xb(8'h02, rb); xb(8'h00, rb); xb(8'h20, rb);
        xb(8'h77, rb); bits(8'hFF, 3, rb); desel();
        chk("R11 mid-byte strobes", 32'(n_dat - d0), 32'd1);
        chk("R11 mid-byte no commit", 32'(n_cmt - c0), 32'd0);

        // R10 R11 status write
        d0 = n_dat; c0 = n_cmt;
        sel(); xb(8'h01, rb); xb(8'h8C, rb); desel();
        chk("R10 status data", 32'(last_dat), 32'h8C);
        chk("R11 status commit", 32'(n_cmt - c0), 32'd1);
        chk("R11 status kind", 32'(last_cst), 32'd1);

        // R8 busy behaviour
        prog_busy = 1'b1;
        rdsr("R8 busy status", 8'hFF);
        d0 = n_dat; c0 = n_cmt;
        sel(); xb(8'h02, rb); xb(8'h00, rb); xb(8'h05, rb); xb(8'h99, rb); desel();
        chk("R8 write ignored strobes", 32'(n_dat - d0), 32'd0);
        chk("R8 write ignored commit", 32'(n_cmt - c0), 32'd0);
        sel(); xb(8'h03, rb); xb(8'h00, rb); xb(8'h05, rb); xb(8'h00, rb);
        chk("R8 read gives no drive", 32'(spi_sdo_oe), 32'd0);
        desel();

        // R7 busy falling clears write-enable
        prog_busy = 1'b0; wen_m = 1'b0;
        repeat (3) @(negedge clk);
        rdsr("R7 cleared by busy end", {6'b000001, wen_m, 1'b0});

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule